// File: doc/BRIEF.md
# 64b/66b Block Encoder with Self-Synchronous Scrambler

This block takes one 64-bit word per clock from a media-independent transmit path and turns it into a 66-bit line block. The word is eight byte lanes with one control flag per lane. Lane 0 sits in bits [7:0] and is the first byte in time. Lane k sits in bits [8k+7:8k], and its flag is `in_ctrl[k]`. From the flags the block chooses a two-bit sync header. For a word that carries control, it replaces the first payload byte with a block-type byte and lays out the remaining bytes by block type.

The 64-bit payload then passes through a self-synchronous scrambler with taps at positions 39 and 58. The header is not scrambled. The output is one 66-bit block per accepted word, produced exactly one clock after it is accepted. Words presented with `in_valid` low are not encoded and do not advance the scrambler. Reset is asynchronous and active low, and it is released synchronously inside the block through two flops.

Top module: `enc66_top`

## Requirements
- R1: During reset and after its release, `out_valid` is 0 and `out_block` is all zeros. The scrambler state is restored to the parameter `SEED`, and the first block after reset is scrambled from that state.
- R2: `out_valid` equals `in_valid` of the previous cycle. In any cycle where `out_valid` is 0, `out_block` keeps its previous value.
- R3: The header sits in `out_block[1:0]` and is never scrambled. It is 2'b01 when all eight flags are 0 and 2'b10 when any flag is 1. The scrambled payload occupies `out_block[65:2]`, with payload bit 0 at `out_block[2]`.
- R4: For an all-data word (`in_ctrl` = 8'h00), the unscrambled payload equals `in_data` unchanged.
- R5: For an idle word, the payload is 64'h1E: type byte 8'h1E, and seven zero bytes that encode eight zero 7-bit idle codes. An idle word has `in_ctrl` = 8'hFF and every lane equal to 8'h07.
- R6: A start word has `in_ctrl` = 8'h01 and lane 0 equal to 8'hFB. Its payload has type byte 8'h78 in byte 0, and lanes 1..7 unchanged in bytes 1..7.
- R7: A terminate word at lane k (k = 0..7) has `in_ctrl` = 8'hFF << k, lane k equal to 8'hFD, and every lane above k equal to 8'h07. Its payload carries type byte 87, 99, AA, B4, CC, D2, E1 or FF (hex, for k = 0..7) in byte 0. Lanes 0..k-1 go to bytes 1..k and all higher bytes are zero.
- R8: Any other word with at least one flag set becomes an error block. Its payload has type byte 8'h1E, followed by eight 7-bit codes of 7'h1E packed upward from bit 8.
- R9: Scrambling runs from payload bit 0 to bit 63. Each output bit is the payload bit XOR state bit 38 XOR state bit 57. After each bit, the state shifts up by one and the output bit enters at bit 0.
- R10: The scrambler state changes only in cycles where `in_valid` is 1, so gaps in the input do not disturb the scrambled sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 64 | Eight byte lanes, lane 0 in bits [7:0] |
| in_ctrl | input | 8 | Per-lane control flag, bit k for lane k |
| out_valid | output | 1 | `out_block` holds a new block |
| out_block | output | 66 | Header in [1:0], scrambled payload in [65:2] |

## Verification
The bench targets the classification edges. It drives a terminate at each of the eight lane positions, and near-miss patterns: a start with the wrong lane-0 byte, a terminate whose tail is not idle, and an all-flags word with one non-idle byte. A design that mis-decodes any of these emits the wrong type byte or the wrong byte layout, and the per-cycle compare against the reference shows this at once. Idle gaps between words check that the scrambler state is frozen; a design that advanced it anyway would corrupt every later block. A mid-run reset checks that the seed is reloaded. A wrong tap or bit order corrupts every data block from the first one.

// File: rtl/enc66_pkg.sv
package enc66_pkg;
  localparam int NLANES  = 8;
  localparam int LANE_W  = 8;
  localparam int WORD_W  = NLANES * LANE_W;
  localparam int SCR_LEN = 58;
  localparam int TAP_A   = 38;
  localparam int TAP_B   = 57;

  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;

  localparam logic [7:0] BT_IDLE  = 8'h1E;
  localparam logic [7:0] BT_START = 8'h78;
  localparam logic [6:0] CC_ERR   = 7'h1E;

  function automatic logic [7:0] term_type(input int k);
    case (k)
      0: term_type = 8'h87;
      1: term_type = 8'h99;
      2: term_type = 8'hAA;
      3: term_type = 8'hB4;
      4: term_type = 8'hCC;
      5: term_type = 8'hD2;
      6: term_type = 8'hE1;
      default: term_type = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/enc66_rstsync.sv
module enc66_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/enc66_former.sv
module enc66_former
  import enc66_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic [NLANES-1:0] ctrl,
  output logic [1:0]        hdr,
  output logic [WORD_W-1:0] payload
);
  logic [LANE_W-1:0] lane [NLANES];
  logic [NLANES-1:0] is_idle_ch;
  logic [NLANES-1:0] term_hit;
  logic              all_idle;
  logic              start_hit;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lane[g]       = data[g*LANE_W +: LANE_W];
    assign is_idle_ch[g] = (data[g*LANE_W +: LANE_W] == CH_IDLE);
  end

  assign all_idle  = (&ctrl) && (&is_idle_ch);
  assign start_hit = (ctrl == NLANES'(1)) && (lane[0] == CH_START);

  always_comb begin
    for (int k = 0; k < NLANES; k++) begin
      logic tail_ok;
      tail_ok = 1'b1;
      for (int j = k + 1; j < NLANES; j++) tail_ok = tail_ok & is_idle_ch[j];
      term_hit[k] = (ctrl == ({NLANES{1'b1}} << k)) && (lane[k] == CH_TERM) && tail_ok;
    end
  end

  always_comb begin
    hdr     = (ctrl == '0) ? HDR_DATA : HDR_CTRL;
    payload = {{NLANES{CC_ERR}}, BT_IDLE};
    if (ctrl == '0) begin
      payload = data;
    end else if (all_idle) begin
      payload = {{(WORD_W-LANE_W){1'b0}}, BT_IDLE};
    end else if (start_hit) begin
      payload = {data[WORD_W-1:LANE_W], BT_START};
    end else begin
      for (int k = 0; k < NLANES; k++) begin
        if (term_hit[k]) begin
          payload = '0;
          payload[LANE_W-1:0] = term_type(k);
          for (int j = 0; j < k; j++) payload[(j+1)*LANE_W +: LANE_W] = lane[j];
        end
      end
    end
  end
endmodule

// File: rtl/enc66_scrambler.sv
module enc66_scrambler
  import enc66_pkg::*;
#(
  parameter logic [SCR_LEN-1:0] SEED = {SCR_LEN{1'b1}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [WORD_W-1:0]  din,
  output logic [WORD_W-1:0]  dout,
  output logic [SCR_LEN-1:0] state
);
  logic [SCR_LEN-1:0] state_nxt;

  always_comb begin
    logic [SCR_LEN-1:0] s;
    s = state;
    for (int i = 0; i < WORD_W; i++) begin
      dout[i] = din[i] ^ s[TAP_A] ^ s[TAP_B];
      s = {s[SCR_LEN-2:0], dout[i]};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state <= SEED;
    else if (en) state <= state_nxt;
  end
endmodule

// File: rtl/enc66_top.sv
module enc66_top
  import enc66_pkg::*;
#(
  parameter logic [SCR_LEN-1:0] SEED = 58'h155_5555_5555_5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [NLANES-1:0] in_ctrl,
  output logic              out_valid,
  output logic [WORD_W+1:0] out_block
);
  logic               rst_sync_n;
  logic [1:0]         hdr;
  logic [WORD_W-1:0]  payload;
  logic [WORD_W-1:0]  scr_payload;
  logic [SCR_LEN-1:0] scr_state;
  logic               valid_d;
  logic [WORD_W+1:0]  block_d;

  enc66_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  enc66_former u_form (
    .data(in_data), .ctrl(in_ctrl), .hdr(hdr), .payload(payload)
  );

  enc66_scrambler #(.SEED(SEED)) u_scr (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid),
    .din(payload), .dout(scr_payload), .state(scr_state)
  );

  always_comb begin
    valid_d = in_valid;
    block_d = in_valid ? {scr_payload, hdr} : out_block;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_block <= '0;
    end else begin
      out_valid <= valid_d;
      out_block <= block_d;
    end
  end
endmodule

// File: rtl/enc66_chk.sv
module enc66_chk
  import enc66_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [NLANES-1:0]  in_ctrl,
  input logic               out_valid,
  input logic [WORD_W+1:0]  out_block,
  input logic [SCR_LEN-1:0] scr_state
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_block));
  a_r3_hdr_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl == '0) |=> out_block[1:0] == HDR_DATA);
  a_r3_hdr_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl != '0) |=> out_block[1:0] == HDR_CTRL);
  a_r10_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(scr_state));
endmodule

bind enc66_top enc66_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
  .out_valid(out_valid), .out_block(out_block), .scr_state(scr_state)
);

// File: tb/sim_enc66_top.sv
module sim_enc66_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [57:0] TB_SEED = 58'h2F0_1234_5678_9ABC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        out_valid;
  logic [65:0] out_block;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [57:0] ref_state;
  logic [65:0] ref_last;

  enc66_top #(.SEED(TB_SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .out_valid(out_valid), .out_block(out_block)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  function automatic logic [65:0] model_encode(input logic [63:0] d, input logic [7:0] c,
                                               output string tag);
    byte unsigned b[8];
    logic [63:0] p;
    logic [1:0]  h;
    int tpos;
    bit ok;
    byte unsigned tt[8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
    for (int i = 0; i < 8; i++) b[i] = d[8*i +: 8];
    h = (c == 0) ? 2'b01 : 2'b10;
    tag = "R8";
    p = {8{8'h3C}} >> 0;
    p = '0;
    for (int i = 0; i < 8; i++) p[8 + 7*i +: 7] = 7'h1E;
    p[7:0] = 8'h1E;
    if (c == 0) begin
      p = d; tag = "R4";
    end else if (c == 8'hFF && b[0] == 8'h07 && b[1] == 8'h07 && b[2] == 8'h07 && b[3] == 8'h07 &&
                 b[4] == 8'h07 && b[5] == 8'h07 && b[6] == 8'h07 && b[7] == 8'h07) begin
      p = 64'h1E; tag = "R5";
    end else if (c == 8'h01 && b[0] == 8'hFB) begin
      p = d; p[7:0] = 8'h78; tag = "R6";
    end else begin
      tpos = -1;
      for (int k = 0; k < 8; k++) if (c == 8'(8'hFF << k)) tpos = k;
      if (tpos >= 0 && b[tpos] == 8'hFD) begin
        ok = 1;
        for (int j = tpos + 1; j < 8; j++) if (b[j] != 8'h07) ok = 0;
        if (ok) begin
          p = '0; p[7:0] = tt[tpos];
          for (int j = 0; j < tpos; j++) p[8*(j+1) +: 8] = b[j];
          tag = "R7";
        end
      end
    end
    for (int i = 0; i < 64; i++) begin
      logic o;
      o = p[i] ^ ref_state[38] ^ ref_state[57];
      p[i] = o;
      ref_state = {ref_state[56:0], o};
    end
    return {p, h};
  endfunction

  task automatic check(input bit cond, input string req, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] d, input logic [7:0] c);
    string tag;
    logic [65:0] exp;
    @(negedge clk);
    in_valid = v; in_data = d; in_ctrl = c;
    exp = ref_last;
    if (v) begin
      exp = model_encode(d, c, tag);
      ref_last = exp;
    end else tag = "R2 R10";
    @(posedge clk); #1;
    check(out_valid == v, "R2 valid", {65'b0, out_valid}, {65'b0, v});
    check(out_block == exp, {tag, " R3 R9 block"}, out_block, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 valid in reset", {65'b0, out_valid}, 66'd0);
    check(out_block == '0, "R1 block in reset", out_block, 66'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ref_state = TB_SEED;
    ref_last = '0;
    check(out_valid == 1'b0, "R1 valid after release", {65'b0, out_valid}, 66'd0);
    check(out_block == '0, "R1 block after release", out_block, 66'd0);
  endtask

  function automatic logic [63:0] term_word(input int k, input logic [63:0] d);
    logic [63:0] w;
    w = d;
    w[8*k +: 8] = 8'hFD;
    for (int j = k + 1; j < 8; j++) w[8*j +: 8] = 8'h07;
    return w;
  endfunction

  initial begin
    while (cycles < 100000 && !done) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ref_state = TB_SEED;
    ref_last = '0;
    do_reset();
    // R9: first block after reset scrambled from the seed
    step(1, 64'h0, 8'h00);
    // R5 idle
    step(1, {8{8'h07}}, 8'hFF);
    // R6 start
    step(1, 64'h1122_3344_5566_77FB, 8'h01);
    // R4 data, distinct patterns
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    step(1, 64'hDEAD_BEEF_0123_4567, 8'h00);
    // R10: gaps do not advance the scrambler, R2 hold
    step(0, 64'hAAAA_AAAA_AAAA_AAAA, 8'h00);
    step(0, 64'h5555_5555_5555_5555, 8'hFF);
    step(1, 64'hA5A5_5A5A_0F0F_F0F0, 8'h00);
    // R7 terminate at each lane
    for (int k = 0; k < 8; k++) step(1, term_word(k, 64'h8877_6655_4433_2211), 8'(8'hFF << k));
    // R8 error patterns
    step(1, 64'h1122_3344_5566_77FC, 8'h01);
    step(1, 64'h0707_0707_0708_FD11, 8'hFE);
    step(1, 64'h0707_0707_0707_0700, 8'hFF);
    step(1, 64'h0, 8'h10);
    step(1, {8{8'h07}}, 8'h7F);
    // mixed random stream with gaps
    for (int n = 0; n < 300; n++) begin
      logic [63:0] d;
      int sel;
      d = {$urandom, $urandom};
      sel = $urandom_range(0, 9);
      case (sel)
        0: step(0, d, 8'h00);
        1: step(1, {8{8'h07}}, 8'hFF);
        2: step(1, {d[63:8], 8'hFB}, 8'h01);
        3: begin
             int k;
             k = $urandom_range(0, 7);
             step(1, term_word(k, d), 8'(8'hFF << k));
           end
        4: step(1, d, 8'($urandom));
        default: step(1, d, 8'h00);
      endcase
    end
    // R1: mid-run reset reloads the seed
    do_reset();
    step(1, 64'h0, 8'h00);
    step(1, 64'h0123_4567_89AB_CDEF, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule